// File: doc/BRIEF.md
# Two-Wire Slave Register Port with Auto-Incrementing Pointer

This block is a two-wire (I2C) slave that owns a small bank of eight byte-wide registers and answers at the 7-bit bus address 1101000. The bus master first writes a byte that loads an internal word pointer. Any further bytes in the same write land at the pointer, and the pointer steps forward after each one. A read returns the byte at the pointer. The pointer moves on only when the master acknowledges, so a read that was never acknowledged can be repeated without losing its place. A read may begin without a pointer write, and then it continues from wherever the pointer was left.

SCL and SDA arrive asynchronously. Each passes through a two-flop synchroniser clocked by the system clock, and START, STOP and SCL edges are detected on the synchronised levels. The block drives SDA only as an open-drain pull-down through `sda_oe`. A power-good input, `pwr_ok`, guards the whole port. While it is low, any transfer in progress is abandoned, the pointer is cleared and the bus is ignored.

The controller uses these states:
- `ST_IDLE`: not addressed.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_PTR`: receiving the word pointer.
- `ST_PTR_ACK`: acknowledging the pointer.
- `ST_WDATA`: receiving a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte.
- `ST_RDATA`: shifting a byte out.
- `ST_RDATA_ACK`: sampling the master's acknowledge.

Transitions:
- From any state, START goes to `ST_ADDR`, and STOP or a low `pwr_ok` goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match after eight bits, and to `ST_IDLE` otherwise.
- `ST_ADDR_ACK` goes to `ST_RDATA` for a read and to `ST_PTR` for a write.
- `ST_PTR` goes to `ST_PTR_ACK`, and `ST_PTR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RDATA_ACK` after eight bits.
- `ST_RDATA_ACK` goes to `ST_RDATA` on a master ACK and to `ST_IDLE` on a NACK.

Except for START, STOP and power loss, every transition takes place on a falling SCL edge.

Top module: `twi_reg_port`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state. A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R2: The address byte is received MSB first, with the R/W flag in bit 0. The values D0h (write) and D1h (read) are acknowledged by pulling SDA low for the ninth clock. Any other address gets no acknowledge, and the slave stays silent until the next START.
- R3: In a write, the first byte after D0h is acknowledged and loads the pointer from its low three bits. Every later byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R4: The pointer wraps from 7 to 0. A single transfer may carry any number of bytes.
- R5: In a read, the register at the pointer is sent MSB first. A master ACK (SDA low on the ninth clock) advances the pointer, and the next register follows.
- R6: A master NACK leaves the pointer unchanged, and the slave keeps SDA released until the next START.
- R7: A read issued without a preceding pointer write starts at the pointer value left by the last transfer.
- R8: A repeated START after a pointer write restarts address reception and keeps the pointer, so a following read starts at that pointer.
- R9: While `pwr_ok` is low, the transfer in progress is abandoned, SDA is released and the pointer is 0. No address is acknowledged and no register is written. After `pwr_ok` returns, the registers hold their earlier contents.
- R10: The slave changes `sda_oe` only while the synchronised SCL is low, never during an SCL high phase.
- R11: After reset, all registers read 0, the pointer is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply in tolerance; low aborts and blocks the port |
| scl_i | input | 1 | Bus clock level as seen on the pad |
| sda_i | input | 1 | Bus data level as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |

## Verification
The bench sweeps every start pointer from 0 to 7 with write bursts of one to three bytes. Each burst is followed by a current-address read of the same length, which tells apart a pointer that increments, fails to wrap, or forgets its position between transfers. A 19-byte burst checks the wrap under a long transfer. A pointer write followed by a repeated START confirms that the pointer survives the restart. Foreign addresses and a read ended by a NACK, which is then read again, separate an acknowledge-driven pointer from one that advances on every byte. A supply drop in the middle of an acknowledge shows that SDA is released, the pointer is cleared, and nothing is acknowledged or written until `pwr_ok` returns.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } twi_state_e;

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = en &  scl_lvl & ~scl_d;
    assign scl_fall  = en & ~scl_lvl &  scl_d;
    assign start_det = en &  scl_lvl &  scl_d & sda_d & ~sda_lvl;
    assign stop_det  = en &  scl_lvl &  scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/twi_regbank.sv
module twi_regbank #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] bank [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == AW'(g))) begin
                q <= wdata;
            end
        end
        assign bank[g] = q;
    end

    assign rdata = bank[raddr];

endmodule

// File: rtl/twi_slave_ctrl.sv
module twi_slave_ctrl
    import twi_pkg::*;
#(
    parameter int         DEPTH    = 8,
    parameter int         DW       = 8,
    parameter logic [6:0] DEV_ADDR = 7'h68,
    localparam int        AW       = $clog2(DEPTH),
    localparam int        CW       = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] rd_addr,
    output logic          sda_oe
);

    twi_state_e    state, nstate;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] tx;
    logic [AW-1:0] ptr;
    logic          rw_q;
    logic          mack_q;
    logic          byte_done;

    assign byte_done = scl_fall && (cnt == CW'(DW));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        if (!pwr_ok) begin
            nstate = ST_IDLE;
        end else if (start_det) begin
            nstate = ST_ADDR;
        end else if (stop_det) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_ADDR:      if (byte_done)
                                  nstate = (shreg[DW-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) nstate = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) nstate = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall)  nstate = ST_WDATA;
                ST_WDATA:     if (byte_done) nstate = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nstate = ST_WDATA;
                ST_RDATA:     if (scl_fall && (cnt == CW'(DW - 1))) nstate = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall)  nstate = mack_q ? ST_RDATA : ST_IDLE;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // datapath: shift registers, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shreg  <= '0;
            tx     <= '0;
            ptr    <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else if (!pwr_ok) begin
            cnt    <= '0;
            ptr    <= '0;
            mack_q <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[DW-2:0], sda_lvl};
                        cnt   <= cnt + CW'(1);
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR) rw_q <= shreg[0];
                        if (state == ST_PTR)  ptr  <= shreg[AW-1:0];
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_q) begin
                        tx  <= rd_data;
                        cnt <= '0;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) ptr <= ptr + AW'(1);
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx  <= {tx[DW-2:0], 1'b1};
                        cnt <= (cnt == CW'(DW - 1)) ? '0 : cnt + CW'(1);
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_lvl;
                    end else if (scl_fall && mack_q) begin
                        ptr <= ptr + AW'(1);
                        tx  <= rd_data;
                        cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx[DW-1];
            default:                               sda_oe = 1'b0;
        endcase
        wr_en   = pwr_ok && !start_det && !stop_det && (state == ST_WDATA) && byte_done;
        wr_addr = ptr;
        wr_data = shreg;
        rd_addr = (state == ST_RDATA_ACK) ? ptr + AW'(1) : ptr;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && $past(pwr_ok) && $past(state) != ST_PTR && ptr != $past(ptr))
        |-> ptr == $past(ptr) + AW'(1)); // R4

    AST_NACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && state == ST_RDATA_ACK && scl_fall && !mack_q && !start_det && !stop_det)
        |=> (ptr == $past(ptr) && state == ST_IDLE)); // R6

    AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR)
        |-> $past(shreg[DW-1:1]) == DEV_ADDR); // R2

    AST_PWR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (ptr == '0 && !wr_en)); // R9

endmodule

// File: rtl/twi_reg_port.sv
module twi_reg_port #(
    parameter int         REG_DEPTH   = 8,
    parameter int         DATA_W      = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = $clog2(REG_DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    logic          scl_lvl, sda_lvl;
    logic          scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    twi_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (pwr_ok),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_slave_ctrl #(.DEPTH(REG_DEPTH), .DW(DATA_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .sda_oe    (sda_oe)
    );

    twi_regbank #(.DEPTH(REG_DEPTH), .DW(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && $past(pwr_ok) && scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe)); // R10

    AST_PWR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !sda_oe); // R9

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && stop_det) |=> !sda_oe); // R1

endmodule

// File: tb/test_twi_reg_port.sv
module test_twi_reg_port;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [7:0] mem [8];
    int   ptr_m = 0;

    always #2 clk = ~clk;

    twi_reg_port i_twi_reg_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;  wt(Q/2);
        scl_m = 1'b1; wt(Q);
        scl_m = 1'b0; wt(Q/2);
    endtask

    task automatic bit_in(output logic b);
        logic early;
        sda_m = 1'b1; wt(Q/2);
        scl_m = 1'b1; wt(2);
        early = sda_oe;
        wt(Q/2 - 2);
        b = sda_bus;
        wt(Q/2 - 1);
        chk(early == sda_oe, "R10 sda_oe stable in high phase", {7'd0, sda_oe}, {7'd0, early});
        wt(1);
        scl_m = 1'b0; wt(Q/2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q/2);
        scl_m = 1'b1; wt(Q/2);
        sda_m = 1'b0; wt(Q/2);
        scl_m = 1'b0; wt(Q/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q/2);
        scl_m = 1'b1; wt(Q/2);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        acked = !a;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            b[i] = x;
        end
        bit_out(!mack);
    endtask

    function automatic logic [7:0] pat(input int p, input int k, input int s);
        return 8'(p * 53 + k * 29 + s * 7 + 1);
    endfunction

    // write burst of n bytes from pointer p
    task automatic wr_seq(input int p, input int n, input int s);
        bit a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD0, a); chk(a, "R2 write address ack", {7'd0, a}, 8'd1);
        send_byte(8'(p), a); chk(a, "R3 pointer byte ack", {7'd0, a}, 8'd1);
        ptr_m = p;
        for (int k = 0; k < n; k++) begin
            v = pat(p, k, s);
            send_byte(v, a); chk(a, "R3 data byte ack", {7'd0, a}, 8'd1);
            mem[ptr_m] = v;
            ptr_m = (ptr_m + 1) % 8;
        end
        bus_stop();
    endtask

    // read n bytes; optionally set pointer first and use repeated START
    task automatic rd_seq(input bit set_ptr, input int p, input int n, input string tag);
        bit a;
        logic [7:0] v;
        bus_start();
        if (set_ptr) begin
            send_byte(8'hD0, a); chk(a, "R2 write address ack", {7'd0, a}, 8'd1);
            send_byte(8'(p), a); chk(a, "R3 pointer byte ack", {7'd0, a}, 8'd1);
            ptr_m = p;
            bus_start(); // repeated START, R8
        end
        send_byte(8'hD1, a); chk(a, "R2 read address ack", {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, v);
            chk(v == mem[ptr_m], tag, v, mem[ptr_m]);
            if (k < n - 1) ptr_m = (ptr_m + 1) % 8;
        end
        wt(2);
        chk(sda_oe == 1'b0, "R6 released after NACK", {7'd0, sda_oe}, 8'd0);
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] v0, v1;
        for (int i = 0; i < 8; i++) mem[i] = 8'd0;
        wt(5);
        chk(sda_oe == 1'b0, "R11 sda released in reset", {7'd0, sda_oe}, 8'd0);
        rst_n = 1'b1;
        wt(5);

        // R11: registers read zero, pointer starts at 0 (current-address read)
        rd_seq(1'b0, 0, 8, "R11 reset contents / R5 sequential read");

        // R3 R5 R7 R4: sweep all start pointers and short burst lengths
        for (int p = 0; p < 8; p++) begin
            for (int n = 1; n <= 3; n++) begin
                wr_seq(p, n, n);
                rd_seq(1'b0, 0, n, "R7 current-address read / R4 wrap");
            end
        end

        // R4: long burst that wraps twice, then R8 read via repeated START
        wr_seq(5, 19, 9);
        rd_seq(1'b1, 5, 10, "R8 repeated-start read / R4 long burst");

        // R2: foreign addresses get no acknowledge and change nothing
        bus_start();
        send_byte(8'hD2, a); chk(!a, "R2 foreign address D2 no ack", {7'd0, a}, 8'd0);
        bus_stop();
        bus_start();
        send_byte(8'hA0, a); chk(!a, "R2 foreign address A0 no ack", {7'd0, a}, 8'd0);
        bus_stop();
        rd_seq(1'b0, 0, 1, "R2 pointer untouched by foreign address");

        // R6: a NACKed byte is returned again by the next current read
        rd_seq(1'b1, 3, 1, "R6 first NACK read");
        bus_start();
        send_byte(8'hD1, a);
        recv_byte(1'b0, v0);
        bus_stop();
        chk(v0 == mem[3], "R6 pointer not advanced by NACK", v0, mem[3]);

        // R9: supply drop during a data acknowledge
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h06, a);
        ptr_m = 6;
        for (int i = 7; i >= 0; i--) bit_out(v0[i] ^ 1'b1);
        mem[6] = ~v0;           // stored when the byte completed
        wt(2);
        chk(sda_oe == 1'b1, "R3 ack driven during ninth clock", {7'd0, sda_oe}, 8'd1);
        pwr_ok = 1'b0;
        wt(3);
        chk(sda_oe == 1'b0, "R9 sda released on supply loss", {7'd0, sda_oe}, 8'd0);
        wt(Q);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a); chk(!a, "R9 no ack while supply low", {7'd0, a}, 8'd0);
        send_byte(8'h02, a);
        send_byte(8'h5A, a); chk(!a, "R9 no write ack while supply low", {7'd0, a}, 8'd0);
        bus_stop();
        pwr_ok = 1'b1;
        ptr_m = 0;
        wt(Q);
        rd_seq(1'b0, 0, 8, "R9 pointer cleared, contents kept");

        // R1: START in mid-byte restarts addressing; STOP leaves SDA free
        bus_start();
        send_byte(8'hD0, a);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        send_byte(8'hD1, a); chk(a, "R1 START mid-byte restarts address", {7'd0, a}, 8'd1);
        recv_byte(1'b0, v1);
        chk(v1 == mem[ptr_m], "R1 R8 pointer kept across restart", v1, mem[ptr_m]);
        bus_stop();
        wt(3);
        chk(sda_oe == 1'b0, "R1 idle after STOP", {7'd0, sda_oe}, 8'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule